// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between a 6502-style CPU bus and a cartridge holding a 64 KiB flash and a 32 KiB SRAM. For every access to the cartridge half of the map (A12 high) it produces the upper memory address lines A7-A15 and a select that picks RAM or flash. Address lines A0-A6 of both memories are wired straight to the CPU bus and do not pass through the block. The cartridge space is cut into four regions:

- a lower 2 KiB window at $1000-$17FF, placed in 2 KiB blocks;
- a middle window at $1800-$1DFF, also placed in 2 KiB blocks;
- an upper 256-byte window at $1E00-$1EFF, placed in 256-byte pages;
- a fixed 256-byte page at $1F00-$1FFF that always reads the top page of flash.

Software moves the windows by touching hotspot addresses. Absolute hotspots live only in $6000-$7FFF. Page-number selectors let a pointer's high byte index the selector directly. Single-cycle toggle hotspots sit over the video-chip write offsets, so a store that was going to happen anyway can also flip one bank bit. Zero-page hotspots load and recall four presets for the lower window.

A read of $1Fxx directly after a read of $1Exx is taken from the upper window, so an indexed load that crosses the page boundary wraps within 256 bytes.

Bus cycles are marked by `bus_end`. This is a one-`clk` pulse that the surrounding logic raises at the falling edge of phase 2, once address, data and direction are settled. All register updates happen on that pulse, and the new mapping applies from the next bus cycle. The memory lines are a combinational function of the present address and the registers. There is no data stream, so the block has no valid/ready handshake.

Top module: `cart_mapper`

## Requirements
- R1: After reset the lower and middle windows map flash block 0, and the upper window maps flash page 0. The fixed page $1Fxx maps flash page $FF, giving `mem_hi` = {8'hFF, A7} and `mem_ram` = 0. All four presets are block 0 of flash.
- R2: For A12 = 0, `mem_hi` = 0 and `mem_ram` = 0. For the windows:
  - $1000-$17FF gives `mem_hi` = {lower block[4:0], A10..A7};
  - $1800-$1DFF gives `mem_hi` = {middle block, A10..A7};
  - $1E00-$1EFF gives `mem_hi` = {upper page[7:0], A7}.
  In each case `mem_ram` is that window's RAM bit.
- R3: An access of either direction to $68pp loads the lower window with block = pp[7:3] and RAM = pp[2]. An access to $69pp loads the middle window the same way.
- R4: An access of either direction to $6App sets the upper page to pp from flash. An access to $6Bpp sets the upper page to pp from RAM.
- R5: A write to $74xx or $75xx with A7 = 0 toggles one bit:
  - $74xx acts on the lower block and $75xx on the upper page;
  - A6 = 0 toggles memory line A11 (lower block bit 0, upper page bit 3);
  - A6 = 1 toggles A12 (lower block bit 1, upper page bit 4).
  Reads of these addresses, and writes with A7 = 1, change nothing.
- R6: An access outside $6000-$7FFF and outside $0000-$00FF never changes a bank register or a preset.
- R7: A zero-page write to $F8-$FB loads the lower window with block = data[7:3] and RAM = data[2]. A write to $78-$7B ignores the data and loads block = A0 and RAM = A1.
- R8: A zero-page write to $F4-$F7 or $74-$77 stores preset A1..A0 in the same data format as R7. A zero-page read of $FC-$FF or $7C-$7F copies preset A1..A0 into the lower window. Writes to $FC-$FF and reads of $F4-$F7 have no effect.
- R9: A $1Fxx access whose previous bus cycle was in $1E00-$1EFF maps as the upper window. Any other previous cycle, including another $1Fxx access, leaves $1Fxx on the fixed page.
- R10: Registers and the wrap flag change only on cycles with `bus_end` high. A hotspot address present without `bus_end` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_end | input | 1 | One-clock strobe at the end of each CPU bus cycle (phase-2 fall) |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| mem_hi | output | 9 | Memory address lines A7-A15 |
| mem_ram | output | 1 | 1 = SRAM, 0 = flash |

## Verification
The bench builds the block with its package defaults: a 64 KiB memory space, 2 KiB blocks and four presets. These small sizes let the bench sweep every selector byte for both 2 KiB windows and every page of the upper window. It also covers all 64 offsets of each toggle hotspot, every data value of the lower zero-page loader, and every preset slot together with its mirror. With these defaults, every bit of every bank register is driven to both values and seen on `mem_hi`. The wrap flag is exercised by chains of $1Exx and $1Fxx cycles in both orders.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int MEM_AW  = 16;               // external memory address width
  localparam int WIN_LSB = 11;               // 2 KiB window granularity
  localparam int BLK_W   = MEM_AW - WIN_LSB; // block number width
  localparam int PAGE_W  = MEM_AW - 8;       // page number width
  localparam int HI_W    = MEM_AW - 7;       // generated lines A7 and up
  localparam int NPRE    = 4;                // lower-window presets

  typedef enum logic [3:0] {
    HS_NONE, HS_SEL_LO, HS_SEL_MID, HS_SEL_UP_ROM, HS_SEL_UP_RAM,
    HS_TOG_LO, HS_TOG_UP, HS_PRE_WR, HS_LO_DATA, HS_LO_ADDR, HS_PRE_RD
  } hs_cmd_e;

  typedef struct packed {
    logic [BLK_W-1:0] blk;
    logic             ram;
  } blk_sel_t;
endpackage

// File: rtl/cart_hotspot_dec.sv
module cart_hotspot_dec
  import cart_map_pkg::*;
(
  input  logic [15:0]       addr,
  input  logic [7:0]        data,
  input  logic              rd,
  output hs_cmd_e           cmd,
  output blk_sel_t          sel,
  output logic [PAGE_W-1:0] page,
  output logic [1:0]        idx,
  output logic              tog_a12
);
  logic in_hot_range;
  logic in_zp;
  logic dec_unused;

  assign in_hot_range = (addr[15:13] == 3'b011);
  assign in_zp        = (addr[15:8] == 8'h00);
  assign dec_unused   = ^data[1:0];

  always_comb begin
    cmd     = HS_NONE;
    sel     = '{blk: data[7:3], ram: data[2]};
    page    = addr[7:0];
    idx     = addr[1:0];
    tog_a12 = addr[6];
    if (in_hot_range) begin
      case (addr[15:8])
        8'h68: begin cmd = HS_SEL_LO;  sel = '{blk: addr[7:3], ram: addr[2]}; end
        8'h69: begin cmd = HS_SEL_MID; sel = '{blk: addr[7:3], ram: addr[2]}; end
        8'h6A: cmd = HS_SEL_UP_ROM;
        8'h6B: cmd = HS_SEL_UP_RAM;
        8'h74: if (!rd && !addr[7]) cmd = HS_TOG_LO;
        8'h75: if (!rd && !addr[7]) cmd = HS_TOG_UP;
        default: cmd = HS_NONE;
      endcase
    end else if (in_zp && addr[6:4] == 3'b111) begin
      case (addr[3:2])
        2'b01: if (!rd) cmd = HS_PRE_WR;
        2'b10: if (!rd) begin
          if (addr[7]) cmd = HS_LO_DATA;
          else begin
            cmd = HS_LO_ADDR;
            sel = '{blk: {{(BLK_W-1){1'b0}}, addr[0]}, ram: addr[1]};
          end
        end
        2'b11: if (rd) cmd = HS_PRE_RD;
        default: cmd = HS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  hs_cmd_e           cmd,
  input  blk_sel_t          sel,
  input  logic [PAGE_W-1:0] page,
  input  logic [1:0]        idx,
  input  logic              tog_a12,
  output blk_sel_t          lo_q,
  output blk_sel_t          mid_q,
  output logic [PAGE_W-1:0] up_q,
  output logic              up_ram_q
);
  localparam logic [BLK_W-1:0]  LO_A11 = BLK_W'(1);
  localparam logic [BLK_W-1:0]  LO_A12 = BLK_W'(2);
  localparam logic [PAGE_W-1:0] UP_A11 = PAGE_W'(1) << (WIN_LSB - 8);
  localparam logic [PAGE_W-1:0] UP_A12 = PAGE_W'(1) << (WIN_LSB - 7);

  blk_sel_t pre_q [NPRE];

  for (genvar k = 0; k < NPRE; k++) begin : g_pre
    always_ff @(posedge clk) begin
      if (!rst_n) pre_q[k] <= '0;
      else if (upd && cmd == HS_PRE_WR && idx == 2'(k)) pre_q[k] <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q     <= '0;
      mid_q    <= '0;
      up_q     <= '0;
      up_ram_q <= 1'b0;
    end else if (upd) begin
      case (cmd)
        HS_SEL_LO, HS_LO_DATA, HS_LO_ADDR: lo_q <= sel;
        HS_SEL_MID:    mid_q <= sel;
        HS_SEL_UP_ROM: begin up_q <= page; up_ram_q <= 1'b0; end
        HS_SEL_UP_RAM: begin up_q <= page; up_ram_q <= 1'b1; end
        HS_TOG_LO:     lo_q.blk <= lo_q.blk ^ (tog_a12 ? LO_A12 : LO_A11);
        HS_TOG_UP:     up_q <= up_q ^ (tog_a12 ? UP_A12 : UP_A11);
        HS_PRE_RD:     lo_q <= pre_q[idx];
        default: ;
      endcase
    end
  end

  AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(lo_q) && $stable(mid_q) && $stable(up_q) && $stable(up_ram_q))); // R10
endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map
  import cart_map_pkg::*;
(
  input  logic [12:7]       addr,
  input  blk_sel_t          lo,
  input  blk_sel_t          mid,
  input  logic [PAGE_W-1:0] up_page,
  input  logic              up_ram,
  input  logic              wrap,
  output logic [HI_W-1:0]   mem_hi,
  output logic              mem_ram
);
  always_comb begin
    if (!addr[12]) begin
      mem_hi  = '0;
      mem_ram = 1'b0;
    end else if (!addr[11]) begin
      mem_hi  = {lo.blk, addr[10:7]};
      mem_ram = lo.ram;
    end else if (addr[10:9] != 2'b11) begin
      mem_hi  = {mid.blk, addr[10:7]};
      mem_ram = mid.ram;
    end else if (!addr[8] || wrap) begin
      mem_hi  = {up_page, addr[7]};
      mem_ram = up_ram;
    end else begin
      mem_hi  = {{PAGE_W{1'b1}}, addr[7]};
      mem_ram = 1'b0;
    end
  end
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_map_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_end,
  input  logic [15:0]     cpu_addr,
  input  logic [7:0]      cpu_data,
  input  logic            cpu_rw,
  output logic [HI_W-1:0] mem_hi,
  output logic            mem_ram
);
  hs_cmd_e           cmd;
  blk_sel_t          sel;
  logic [PAGE_W-1:0] page;
  logic [1:0]        idx;
  logic              tog_a12;
  blk_sel_t          lo_q, mid_q;
  logic [PAGE_W-1:0] up_q;
  logic              up_ram_q;
  logic              wrap_q;

  cart_hotspot_dec dec_i (
    .addr(cpu_addr), .data(cpu_data), .rd(cpu_rw),
    .cmd(cmd), .sel(sel), .page(page), .idx(idx), .tog_a12(tog_a12)
  );

  cart_bank_regs regs_i (
    .clk(clk), .rst_n(rst_n), .upd(bus_end),
    .cmd(cmd), .sel(sel), .page(page), .idx(idx), .tog_a12(tog_a12),
    .lo_q(lo_q), .mid_q(mid_q), .up_q(up_q), .up_ram_q(up_ram_q)
  );

  // previous bus cycle touched $1Exx
  always_ff @(posedge clk) begin
    if (!rst_n) wrap_q <= 1'b0;
    else if (bus_end) wrap_q <= (cpu_addr[12:8] == 5'h1E);
  end

  cart_addr_map map_i (
    .addr(cpu_addr[12:7]), .lo(lo_q), .mid(mid_q), .up_page(up_q),
    .up_ram(up_ram_q), .wrap(wrap_q), .mem_hi(mem_hi), .mem_ram(mem_ram)
  );

  AST_WRAP_TRACKS_PREV: assert property (@(posedge clk) disable iff (!rst_n)
    bus_end |=> (wrap_q == ($past(cpu_addr[12:8]) == 5'h1E))); // R9

  AST_HOT_RANGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_end && cpu_addr[15:13] != 3'b011 && cpu_addr[15:8] != 8'h00)
      |=> ($stable(lo_q) && $stable(mid_q) && $stable(up_q) && $stable(up_ram_q))); // R6

  AST_TOGGLE_LO_A11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_end && !cpu_rw && cpu_addr[15:8] == 8'h74 && cpu_addr[7:6] == 2'b00)
      |=> (lo_q.blk == ($past(lo_q.blk) ^ BLK_W'(1)) && lo_q.ram == $past(lo_q.ram))); // R5

  AST_ADDR_LOADER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_end && !cpu_rw && cpu_addr[15:2] == 14'h001E)
      |=> (lo_q.blk == BLK_W'($past(cpu_addr[0])) && lo_q.ram == $past(cpu_addr[1]))); // R7

  AST_READ_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_end && cpu_rw && cpu_addr[15:9] == 7'b0111_010)
      |=> ($stable(lo_q) && $stable(up_q))); // R5
endmodule

// File: tb/cart_mapper_tb_top.sv
module cart_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_end = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_rw = 1'b1;
  logic [8:0]  mem_hi;
  logic        mem_ram;

  int n_run = 0;
  int n_fail = 0;

  // bench model of the expected register contents
  logic [4:0] m_lo_blk = 0, m_mid_blk = 0;
  logic       m_lo_ram = 0, m_mid_ram = 0, m_up_ram = 0, m_wrap = 0;
  logic [7:0] m_up_page = 0;

  always #5 clk = ~clk;

  cart_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .bus_end(bus_end), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_rw(cpu_rw), .mem_hi(mem_hi), .mem_ram(mem_ram)
  );

  function automatic logic [9:0] exp_map(input logic [15:0] a);
    if (!a[12])                 return 10'd0;
    else if (!a[11])            return {m_lo_blk, a[10:7], m_lo_ram};
    else if (a[10:9] != 2'b11)  return {m_mid_blk, a[10:7], m_mid_ram};
    else if (!a[8] || m_wrap)   return {m_up_page, a[7], m_up_ram};
    else                        return {8'hFF, a[7], 1'b0};
  endfunction

  task automatic access(input logic [15:0] a, input logic [7:0] d, input logic rd);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = rd; bus_end = 1'b1;
    @(negedge clk);
    bus_end = 1'b0;
    m_wrap = (a[12:8] == 5'h1E);
  endtask

  task automatic check(input logic [15:0] a, input string tag);
    logic [9:0] e;
    @(negedge clk);
    cpu_addr = a; cpu_rw = 1'b1; bus_end = 1'b0;
    #1;
    e = exp_map(a);
    n_run++;
    if ({mem_hi, mem_ram} !== e) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h/%b expected=%h/%b",
               tag, a, mem_hi, mem_ram, e[9:1], e[0]);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 non-cartridge addresses
    check(16'h1000, "R1"); check(16'h1780, "R1"); check(16'h1A00, "R1");
    check(16'h1E80, "R1"); check(16'h1F00, "R1"); check(16'h1FFF, "R1");
    check(16'h0800, "R2"); check(16'hE000, "R2");

    // R3 lower and middle selectors, every byte, both directions
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pp = 8'(p);
      access({8'h68, pp}, 8'h00, pp[0]);
      m_lo_blk = pp[7:3]; m_lo_ram = pp[2];
      check(16'h1000 | {5'd0, pp[3:0], 7'd0}, "R3");
      access({8'h69, pp}, 8'h00, ~pp[0]);
      m_mid_blk = pp[7:3]; m_mid_ram = pp[2];
      check(16'h1800 | (pp[0] ? 16'h0180 : 16'h0000), "R3");
    end

    // R4 upper page selectors, R2 upper window layout
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pp = 8'(p);
      logic r = pp[0] ^ pp[4];
      access({7'b0110101, r, pp}, 8'h00, pp[1]);
      m_up_page = pp; m_up_ram = r;
      check(16'h1E00 | {8'd0, pp[5], 7'd0}, "R4");
    end

    // R5 toggles over every video-chip offset
    access(16'h6800, 8'h00, 1'b1); m_lo_blk = 0; m_lo_ram = 0;
    access(16'h6A00, 8'h00, 1'b1); m_up_page = 0; m_up_ram = 0;
    for (int t = 0; t < 64; t++) begin
      access(16'h7400 | 16'(t), 8'h00, 1'b0); m_lo_blk ^= 5'd1;
      check(16'h1400, "R5");
      access(16'h7440 | 16'(t), 8'h00, 1'b0); m_lo_blk ^= 5'd2;
      check(16'h1400, "R5");
      access(16'h7500 | 16'(t), 8'h00, 1'b0); m_up_page ^= 8'h08;
      check(16'h1E80, "R5");
      access(16'h7540 | 16'(t), 8'h00, 1'b0); m_up_page ^= 8'h10;
      check(16'h1E80, "R5");
    end
    access(16'h7400, 8'h00, 1'b1); check(16'h1000, "R5");  // read ignored
    access(16'h7480, 8'h00, 1'b0); check(16'h1000, "R5");  // A7=1 ignored
    access(16'h7540, 8'h00, 1'b1); check(16'h1E00, "R5");

    // R6 accesses outside the hotspot ranges
    access(16'h6813, 8'h00, 1'b1); m_lo_blk = 5'd2; m_lo_ram = 1'b0;
    access(16'h4868, 8'hFF, 1'b0); check(16'h1000, "R6");
    access(16'hE869, 8'hFF, 1'b1); check(16'h1800, "R6");
    access(16'h01F8, 8'hFF, 1'b0); check(16'h1000, "R6");
    access(16'h2874, 8'hFF, 1'b0); check(16'h1000, "R6");
    access(16'h8A55, 8'hFF, 1'b1); check(16'h1E00, "R6");
    access(16'h00F0, 8'hFF, 1'b0); check(16'h1000, "R6");

    // R7 zero-page lower loaders
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dd = 8'(d);
      access(16'h00F8 | {14'd0, dd[1:0]}, dd, 1'b0);
      m_lo_blk = dd[7:3]; m_lo_ram = dd[2];
      check(16'h1000 | {5'd0, dd[4:1], 7'd0}, "R7");
    end
    access(16'h00F9, 8'h00, 1'b1); check(16'h1000, "R7");  // read ignored
    for (int k = 0; k < 4; k++) begin
      logic [1:0] kk = 2'(k);
      access(16'h0078 | {14'd0, kk}, 8'hFF, 1'b0);
      m_lo_blk = {4'd0, kk[0]}; m_lo_ram = kk[1];
      check(16'h1280, "R7");
    end

    // R8 presets and their mirrors
    access(16'h00FC, 8'h00, 1'b1); m_lo_blk = 0; m_lo_ram = 0;
    check(16'h1000, "R8");                                  // reset preset
    access(16'h00F4, 8'h2C, 1'b0);
    access(16'h00F5, 8'h40, 1'b0);
    access(16'h0076, 8'hFB, 1'b0);
    access(16'h0077, 8'h14, 1'b0);
    access(16'h00FC, 8'h00, 1'b1); m_lo_blk = 5'd5;  m_lo_ram = 1'b1; check(16'h1000, "R8");
    access(16'h007E, 8'h00, 1'b1); m_lo_blk = 5'd31; m_lo_ram = 1'b0; check(16'h1000, "R8");
    access(16'h007D, 8'h00, 1'b1); m_lo_blk = 5'd8;  m_lo_ram = 1'b0; check(16'h1000, "R8");
    access(16'h00FF, 8'h00, 1'b1); m_lo_blk = 5'd2;  m_lo_ram = 1'b1; check(16'h1000, "R8");
    access(16'h00FD, 8'h00, 1'b0); check(16'h1000, "R8");  // write to recall addr ignored
    access(16'h00F6, 8'h00, 1'b1); check(16'h1000, "R8");  // read of store addr ignored
    access(16'h00FD, 8'h00, 1'b1); m_lo_blk = 5'd8;  m_lo_ram = 1'b0; check(16'h1000, "R8");
    access(16'h00F6, 8'h00, 1'b1); check(16'h1000, "R8");
    access(16'h00FE, 8'h00, 1'b1); m_lo_blk = 5'd31; m_lo_ram = 1'b0; check(16'h1000, "R8");

    // R9 wrap from $1Exx into $1Fxx
    access(16'h6B5A, 8'h00, 1'b1); m_up_page = 8'h5A; m_up_ram = 1'b1;
    access(16'h1E33, 8'h00, 1'b1); check(16'h1F44, "R9"); check(16'h1FC4, "R9");
    access(16'h1F44, 8'h00, 1'b1); check(16'h1F44, "R9");
    access(16'h1EFF, 8'h00, 1'b1); check(16'h1F00, "R9");
    access(16'h0100, 8'h00, 1'b1); check(16'h1F00, "R9");
    access(16'h1E00, 8'h00, 1'b0); check(16'h1FFF, "R9");
    access(16'h1D00, 8'h00, 1'b1); check(16'h1FFF, "R9");

    // R10 hotspot present without the cycle strobe
    @(negedge clk);
    cpu_addr = 16'h68FC; cpu_rw = 1'b1; bus_end = 1'b0;
    repeat (3) @(negedge clk);
    cpu_addr = 16'h7400; cpu_rw = 1'b0;
    repeat (3) @(negedge clk);
    check(16'h1000, "R10"); check(16'h1F00, "R10");

    summary();
    $finish;
  end
endmodule